// File: doc/BRIEF.md
# Dual-Phase Serial Audio Framer

The framer moves 16-bit PCM words between a parallel word interface and a single serial data line in each direction. It runs entirely on the system clock: the bit clock and the frame sync arrive as levels that are synchronous to `clk`, and the framer finds their edges itself. A frame opens when the frame sync turns active. The frame holds one phase of words, or two phases back to back, and each phase has its own programmable word count. Bits travel MSB first. The data can begin on the first sampling edge after the frame opens, or one bit later.

Both the bit-clock polarity and the frame-sync polarity can be inverted independently. Stereo I2S is set up as two phases of one word each, with a one-bit delay and a low-active sync. The DSP-style layouts use a single phase of 1, 2 or 4 words and an inverted sync polarity. DSP-A uses a one-bit delay and DSP-B uses no delay. Clock generation, sync generation and word buffering all happen outside the block. The transmit side pulls one word at the start of each word slot, and it sends zeros when its source has no data.

Top module: `serial_audio_framer`

## Requirements
- R1: A frame opens on the clock where the active level of `frm_sync` first appears. The active level is low when `sync_inv`=0 and high when `sync_inv`=1.
- R2: With `bclk_inv`=0, a rising `bit_clk` is the sampling edge and a falling `bit_clk` is the driving edge. With `bclk_inv`=1 the two roles swap.
- R3: With `late_data`=0, bit 0 of the frame is sampled on the first sampling edge after the frame opens, and the transmitter puts it on `tx_line` as the frame opens. With `late_data`=1, that first sampling edge carries no data and every bit moves one bit period later.
- R4: A frame carries `p1_words`+1 words, followed by `p2_words`+1 more words when `two_phase`=1. Each word is 16 bits, MSB first, in both directions.
- R5: `rx_word_ok` goes high for exactly one clock, in the clock after the sampling edge that takes a word's last bit, and `rx_word` then holds that word.
- R6: At the start of each word slot the framer latches `tx_word`, provided transmission is on and `tx_word_ok`=1. `tx_word_taken` goes high for one clock after each such latch.
- R7: When `tx_word_ok`=0 at the start of a slot, that word goes out as all zeros and `tx_word_taken` stays low.
- R8: `tx_enable` is sampled only when a frame opens. If it was low at that moment, `tx_line` stays 0 for the whole frame and no word is taken, even if `tx_enable` rises during the frame.
- R9: From the first driving edge after a frame's last sampled bit until the next frame opens, `tx_line` is 0.
- R10: With `sync_lock`=1, a new sync edge inside a running frame is ignored. With `sync_lock`=0, such an edge restarts the frame: the partial receive word is dropped and the transmitter takes a fresh word.
- R11: During reset and directly after it, `tx_line`, `rx_word_ok` and `tx_word_taken` are 0.
- R12: `tx_line` changes only in the clock where a driving edge or a frame opening is seen, so it holds steady across each sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_clk | input | 1 | Bit clock level, synchronous to clk |
| frm_sync | input | 1 | Frame sync level |
| bclk_inv | input | 1 | Swaps the sampling and driving edges |
| sync_inv | input | 1 | 1 makes the frame sync active high |
| late_data | input | 1 | 1 delays the data by one bit after the frame opens |
| two_phase | input | 1 | Adds the second phase |
| p1_words | input | WCW | Phase-one word count minus one |
| p2_words | input | WCW | Phase-two word count minus one |
| sync_lock | input | 1 | Ignore sync edges inside a frame |
| tx_enable | input | 1 | Transmit on, taken at frame opening |
| tx_word | input | DW | Next word to send |
| tx_word_ok | input | 1 | tx_word is available |
| tx_word_taken | output | 1 | One-clock pulse after a word was latched |
| tx_line | output | 1 | Serial transmit data |
| rx_line | input | 1 | Serial receive data |
| rx_word | output | DW | Last received word |
| rx_word_ok | output | 1 | One-clock pulse when rx_word is new |

## Verification
`tx_line` updates in the same clock that sees a driving edge or a frame opening. `rx_word_ok` and `tx_word_taken` arrive exactly one clock after the edge that causes them. The bench changes its inputs only on falling clock edges and holds each bit-clock level for two clocks. It reads `tx_line` at the falling edge just before it raises the sampling level, which matches what the framer itself would sample. The received-word and taken-word pulses are collected on the falling edges that follow them, and each is compared with a queue of words that the bench builds as its own bit schedule completes each word.

// File: rtl/serial_audio_framer.sv
module serial_audio_framer #(
  parameter int DW  = 16,
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_clk,
  input  logic           frm_sync,
  input  logic           bclk_inv,
  input  logic           sync_inv,
  input  logic           late_data,
  input  logic           two_phase,
  input  logic [WCW-1:0] p1_words,
  input  logic [WCW-1:0] p2_words,
  input  logic           sync_lock,
  input  logic           tx_enable,
  input  logic [DW-1:0]  tx_word,
  input  logic           tx_word_ok,
  output logic           tx_word_taken,
  output logic           tx_line,
  input  logic           rx_line,
  output logic [DW-1:0]  rx_word,
  output logic           rx_word_ok
);
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  logic           lvl_q, act_q, busy, skip, ph, tx_on;
  logic [BCW-1:0] bitc;
  logic [WCW-1:0] wrdc;
  logic [DW-2:0]  rx_sh, tx_sh;

  wire lvl     = bit_clk ^ bclk_inv;
  wire samp_e  = lvl & ~lvl_q;
  wire drv_e   = ~lvl & lvl_q;
  wire act     = sync_inv ? frm_sync : ~frm_sync;
  wire fst     = act & ~act_q & ~(busy & sync_lock);
  wire shift_e = samp_e & busy & ~skip & ~fst;

  wire [WCW-1:0] wlim = ph ? p2_words : p1_words;
  wire word_end  = bitc == LAST_BIT;
  wire phase_end = word_end & (wrdc == wlim);
  wire frame_end = phase_end & (ph | ~two_phase);

  wire load   = fst ? ~late_data : (drv_e & busy & ~skip & (bitc == '0));
  wire on_now = fst ? tx_enable : tx_on;
  wire take   = load & on_now & tx_word_ok;
  wire [DW-1:0] src = take ? tx_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      act_q <= 1'b0;
      busy  <= 1'b0;
      skip  <= 1'b0;
      ph    <= 1'b0;
      tx_on <= 1'b0;
      bitc  <= '0;
      wrdc  <= '0;
    end else begin
      lvl_q <= lvl;
      act_q <= act;
      if (fst) begin
        busy  <= 1'b1;
        skip  <= late_data;
        ph    <= 1'b0;
        tx_on <= tx_enable;
        bitc  <= '0;
        wrdc  <= '0;
      end else if (samp_e && busy) begin
        if (skip) begin
          skip <= 1'b0;
        end else begin
          bitc <= word_end ? '0 : bitc + BCW'(1);
          if (frame_end) begin
            busy <= 1'b0;
          end else if (phase_end) begin
            ph   <= 1'b1;
            wrdc <= '0;
          end else if (word_end) begin
            wrdc <= wrdc + WCW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh      <= '0;
      rx_word    <= '0;
      rx_word_ok <= 1'b0;
    end else begin
      rx_word_ok <= shift_e & word_end;
      if (shift_e) begin
        rx_sh <= {rx_sh[DW-3:0], rx_line};
        if (word_end) rx_word <= {rx_sh, rx_line};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh         <= '0;
      tx_line       <= 1'b0;
      tx_word_taken <= 1'b0;
    end else begin
      tx_word_taken <= take;
      if (load) begin
        tx_line <= src[DW-1];
        tx_sh   <= src[DW-2:0];
      end else if (fst) begin
        tx_line <= 1'b0;
      end else if (drv_e) begin
        if (busy && !skip) begin
          tx_line <= tx_sh[DW-2];
          tx_sh   <= {tx_sh[DW-3:0], 1'b0};
        end else begin
          tx_line <= 1'b0;
        end
      end
    end
  end

  AST_TX_MOVES_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_line) |-> $past(drv_e | fst)); // R12
  AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_ok |=> !rx_word_ok); // R5
  AST_RX_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_ok |-> $past(samp_e)); // R2
  AST_TAKE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_taken |-> $past(tx_word_ok & (tx_enable | tx_on))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_e & ~busy & ~fst) |=> !tx_line); // R9
endmodule

// File: tb/sim_serial_audio_framer.sv
module sim_serial_audio_framer;
  localparam int CLK_NS = 10;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0, bit_clk = 1'b0, frm_sync = 1'b1;
  logic bclk_inv = 1'b0, sync_inv = 1'b0, late_data = 1'b0, two_phase = 1'b0;
  logic [1:0] p1_words = 2'd0, p2_words = 2'd0;
  logic sync_lock = 1'b0, tx_enable = 1'b1, tx_word_ok = 1'b1, rx_line = 1'b0;
  logic [15:0] tx_word = 16'h0;
  wire tx_word_taken, tx_line, rx_word_ok;
  wire [15:0] rx_word;

  int checks = 0, fails = 0, take_cnt = 0, slot = 0, fid = 0, rx_wr = 0, rx_rd = 0;
  bit lvl = 1'b0, done = 1'b0;
  logic [15:0] exp_rx [0:1023];

  always #(CLK_NS/2) clk = ~clk;

  serial_audio_framer u0 (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frm_sync(frm_sync),
    .bclk_inv(bclk_inv), .sync_inv(sync_inv), .late_data(late_data),
    .two_phase(two_phase), .p1_words(p1_words), .p2_words(p2_words),
    .sync_lock(sync_lock), .tx_enable(tx_enable), .tx_word(tx_word),
    .tx_word_ok(tx_word_ok), .tx_word_taken(tx_word_taken), .tx_line(tx_line),
    .rx_line(rx_line), .rx_word(rx_word), .rx_word_ok(rx_word_ok)
  );

  function automatic logic [15:0] fw(int n);
    return 16'(n * 40503 + 4660);
  endfunction

  function automatic logic [15:0] gw(int n);
    return 16'((n * 30011) ^ 23130);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_word_taken) take_cnt++;
    tx_word = fw(take_cnt);
    if (rst_n && rx_word_ok) begin
      if (rx_rd < rx_wr) chk(rx_word == exp_rx[rx_rd], "R5 received word", rx_word, exp_rx[rx_rd]);
      else chk(1'b0, "R5 unexpected word", rx_word, 0);
      rx_rd++;
    end
  end

  task automatic set_lvl(bit v);
    lvl = v;
    bit_clk = v ^ bclk_inv;
  endtask

  task automatic half();
    repeat (H) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(bit d, bit ci, bit fi, bit two, int w1, int w2);
    late_data = d;
    bclk_inv  = ci;
    bit_clk   = lvl ^ ci;
    sync_inv  = fi;
    frm_sync  = fi ? 1'b0 : 1'b1;
    two_phase = two;
    p1_words  = 2'(w1);
    p2_words  = 2'(w2);
    half();
  endtask

  task automatic run_frame(int p, int en_at, string tag);
    int nw, total, d, o, j, e_end, used, fidl, base;
    bit on, act, idle_ok, steady_ok, v;
    logic [15:0] acc, w, expw;
    nw = int'(p1_words) + 1 + (two_phase ? int'(p2_words) + 1 : 0);
    total = nw * 16;
    d = int'(late_data);
    o = 0;
    on = tx_enable;
    base = slot;
    fidl = fid;
    fid++;
    idle_ok = 1'b1;
    steady_ok = 1'b1;
    acc = '0;
    e_end = ((p > 0 && !sync_lock) ? p : 0) + d + total + 3;
    for (int e = 0; e < e_end; e++) begin
      act = (e == 0);
      if (p > 0 && e == p) begin
        act = 1'b1;
        if (!sync_lock) begin
          used = 0;
          for (int k = 0; k < nw; k++) if (o + d + 16 * k < p) used++;
          if (on && tx_word_ok) base += used;
          o = p;
          fidl = fid;
          fid++;
          on = tx_enable;
        end
      end
      if (e == en_at) tx_enable = 1'b1;
      j = e - o - d;
      if (j >= 0 && j < total) begin
        w = gw(fidl * 8 + j / 16);
        rx_line = w[15 - (j % 16)];
      end else begin
        rx_line = 1'b0;
      end
      frm_sync = sync_inv ? act : ~act;
      set_lvl(1'b0);
      half();
      v = tx_line;
      if (j >= 0 && j < total) begin
        acc = {acc[14:0], v};
        if (j % 16 == 15) begin
          expw = (on && tx_word_ok) ? fw(base + j / 16) : 16'h0;
          chk(acc == expw, {tag, " R4 transmitted word"}, acc, expw);
          exp_rx[rx_wr] = gw(fidl * 8 + j / 16);
          rx_wr++;
        end
      end else if (j >= total && v !== 1'b0) begin
        idle_ok = 1'b0;
      end
      set_lvl(1'b1);
      half();
      if (tx_line !== v) steady_ok = 1'b0;
    end
    slot = base + ((on && tx_word_ok) ? nw : 0);
    chk(idle_ok, {tag, " R9 line idle after frame"}, idle_ok, 1);
    chk(steady_ok, {tag, " R12 line steady over sampling edge"}, steady_ok, 1);
    chk(take_cnt == slot, {tag, " R6 words taken"}, take_cnt, slot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    set_lvl(1'b0);
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b0, "R11 tx_line in reset", tx_line, 0);
    chk(rx_word_ok == 1'b0, "R11 rx_word_ok in reset", rx_word_ok, 0);
    chk(tx_word_taken == 1'b0, "R11 tx_word_taken in reset", tx_word_taken, 0);
    rst_n = 1'b1;
    half();
    chk(tx_line == 1'b0 && rx_word_ok == 1'b0 && tx_word_taken == 1'b0,
        "R11 outputs after reset", {tx_line, rx_word_ok, tx_word_taken}, 0);

    // R1 R2 R3 R4: sweep of delay, clock polarity, sync polarity and layouts
    for (int d = 0; d < 2; d++)
      for (int ci = 0; ci < 2; ci++)
        for (int fi = 0; fi < 2; fi++)
          for (int lay = 0; lay < 5; lay++) begin
            case (lay)
              0: set_cfg(d[0], ci[0], fi[0], 1'b0, 0, 0);
              1: set_cfg(d[0], ci[0], fi[0], 1'b0, 1, 0);
              2: set_cfg(d[0], ci[0], fi[0], 1'b0, 3, 0);
              3: set_cfg(d[0], ci[0], fi[0], 1'b1, 0, 0);
              default: set_cfg(d[0], ci[0], fi[0], 1'b1, 1, 2);
            endcase
            run_frame(0, -1, "R1/R2/R3");
          end

    sync_lock = 1'b0;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 3, 0);
    run_frame(22, -1, "R10 restart");
    sync_lock = 1'b1;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 3, 0);
    run_frame(21, -1, "R10 ignored edge");
    sync_lock = 1'b0;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 0, 0);
    tx_enable = 1'b0;
    run_frame(0, 10, "R8 off until frame");
    run_frame(0, -1, "R8 on at next frame");
    tx_word_ok = 1'b0;
    run_frame(0, -1, "R7 no data");
    tx_word_ok = 1'b1;
    run_frame(0, -1, "R6 data again");

    repeat (4) @(negedge clk);
    chk(rx_rd == rx_wr, "R5 received word count", rx_rd, rx_wr);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule